// File: doc/BRIEF.md
# Byte-Wide ADC Readout Controller

This block runs a 12-bit sampling converter from the host side when the converter returns results over an 8-bit tri-state bus. When the block is ready and sees a start request, it pulls chip-select low. After a setup interval it drives the read/convert line low for a programmed number of cycles, and this starts a conversion. The block then waits for the converter's busy flag to rise, which shows that fresh data sits in the converter's output registers. It reads the result as two bytes by switching a byte-select line. It joins the two bytes into a 12-bit word and marks that word with a one-cycle valid strobe.

The block also has an optional mode that re-reads the previous result while the next conversion is still running. That result can only be read for a limited time after the conversion starts. A cycle counter enforces this window, and a read that runs past it is dropped without a strobe. The block never delivers data before the first conversion after reset has finished. A second counter guards against a converter that never raises busy: when it expires, the block sets a sticky error flag and returns to idle. The clock-select output is held high and the serial clock output is held low, so the converter stays in its parallel mode.

Top module: `adc_byte_reader`

## Requirements
- R1: After reset, ready is 1, valid is 0, error is 0, chip-select (active low) is 1 and read/convert is 1. The clock-select output is 1 and the serial clock output is 0 at all times.
- R2: A start accepted while ready holds chip-select low for CS_SETUP cycles with read/convert high. It then drives read/convert low for exactly RC_LOW cycles, and chip-select stays low during that time.
- R3: The bus is sampled only while read/convert is 1 and chip-select is 0. Read/convert, chip-select and byte-select must all have held their values for at least SETTLE cycles before the sample.
- R4: After busy rises, the high byte is read with byte-select 0 and then the low byte with byte-select 1. The result is {high[7:0], low[7:4]}, and low[3:0] is ignored.
- R5: Each assembled word is marked by valid being 1 for exactly one cycle.
- R6: A start while ready is 0 has no effect: each accepted start gives exactly one conversion.
- R7: When the previous-read mode is on and an earlier result exists, the earlier result is read during the conversion and delivered first. The new result is delivered after busy rises.
- R8: In previous-read mode, if WINDOW cycles pass after read/convert falls before the early read completes, that read is dropped with no valid. Only the new result is delivered.
- R9: No previous-read strobe occurs before the first conversion after reset has completed.
- R10: If busy does not rise within TIMEOUT cycles after read/convert falls, the error flag is set, the block returns to ready and no valid is given. The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when ready |
| prev_read_en_i | input | 1 | Enables re-reading the earlier result during a conversion |
| busy_i | input | 1 | Converter busy flag; a rising edge marks new data |
| bus_i | input | 8 | Converter parallel data bus |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rc_o | output | 1 | Read/convert control; low starts a conversion |
| byte_sel_o | output | 1 | 0 selects the high byte, 1 selects the low byte |
| ext_clk_sel_o | output | 1 | Clock-select strap, held high |
| sclk_o | output | 1 | Serial clock, held low |
| result_o | output | 12 | Assembled conversion result |
| valid_o | output | 1 | One-cycle strobe for result_o |
| ready_o | output | 1 | Idle and able to accept a start |
| err_o | output | 1 | Sticky busy timeout flag |

## Verification
The bench builds two copies side by side with CS_SETUP=2, RC_LOW=3 and SETTLE=2. The first copy has WINDOW=40 and the second has WINDOW=4. With the same stimulus, the first copy finishes its early read of the earlier result and the second drops it, so both outcomes of the window are checked in one run. TIMEOUT=50 is set against a modelled conversion time of 20 cycles. Holding the model's busy low therefore reaches the error path within a few dozen cycles, and normal conversions never come near it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CSSU, S_CONV, S_PHI, S_PLO, S_WAIT, S_NHI, S_NLO
  } rd_state_e;

  // Join the two bus reads: the high read carries bits 11..4, the upper
  // nibble of the low read carries bits 3..0.
  function automatic logic [11:0] join_word(input logic [7:0] hi,
                                            input logic [7:0] lo);
    return {hi, lo[7:4]};
  endfunction
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble
  import adc_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_hi,
  input  logic        take_lo,
  input  logic [7:0]  bus_i,
  output logic [11:0] word_o,
  output logic        stb_o
);
  logic [7:0]  hi_q;
  logic [11:0] word_q;
  logic        stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= take_lo;
      if (take_hi) hi_q   <= bus_i;
      if (take_lo) word_q <= join_word(hi_q, bus_i);
    end
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int CS_SETUP = 2,
  parameter int RC_LOW   = 3,
  parameter int SETTLE   = 2,
  parameter int WINDOW   = 200,
  parameter int TIMEOUT  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        prev_read_en_i,
  input  logic        busy_i,
  input  logic [7:0]  bus_i,
  output logic        cs_n_o,
  output logic        rc_o,
  output logic        byte_sel_o,
  output logic        ext_clk_sel_o,
  output logic        sclk_o,
  output logic [11:0] result_o,
  output logic        valid_o,
  output logic        ready_o,
  output logic        err_o
);
  localparam int PW   = $clog2(CS_SETUP + RC_LOW + SETTLE + 2);
  localparam int SMAX = (WINDOW > TIMEOUT) ? WINDOW : TIMEOUT;
  localparam int SW   = $clog2(SMAX + 2);

  rd_state_e state_q, state_d;
  logic [PW-1:0] phase_val;
  logic          phase_load, phase_done;
  logic [1:0]    bsync_q;
  logic          bprev_q, busy_rise, rise_pend_q;
  logic [SW-1:0] since_q;
  logic          win_exp, tmo;
  logic          mode_q, have_q, err_q;
  logic          take_hi, take_lo;
  logic          asm_stb;
  logic [11:0]   asm_word;

  // Busy flag arrives asynchronously: two-flop synchroniser and edge detect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync_q <= 2'b00;
      bprev_q <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[0], busy_i};
      bprev_q <= bsync_q[1];
    end
  end
  assign busy_rise = bsync_q[1] & ~bprev_q;

  // Cycles since read/convert fell; cleared during chip-select setup.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (state_q == S_CSSU) since_q <= '0;
    else if (state_q != S_IDLE && since_q != '1) since_q <= since_q + 1'b1;
  end
  assign win_exp = int'(since_q) >= WINDOW;
  assign tmo     = int'(since_q) >= TIMEOUT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_pend_q <= 1'b0;
    else if (state_q == S_CSSU || state_q == S_IDLE) rise_pend_q <= 1'b0;
    else if (busy_rise) rise_pend_q <= 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_CSSU;
      S_CSSU: if (phase_done) state_d = S_CONV;
      S_CONV: if (phase_done) state_d = (mode_q && have_q) ? S_PHI : S_WAIT;
      S_PHI:  if (win_exp) state_d = S_WAIT;
              else if (phase_done) state_d = S_PLO;
      S_PLO:  if (win_exp || phase_done) state_d = S_WAIT;
      S_WAIT: if (rise_pend_q || busy_rise) state_d = S_NHI;
              else if (tmo) state_d = S_IDLE;
      S_NHI:  if (phase_done) state_d = S_NLO;
      S_NLO:  if (phase_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      S_CSSU:                    phase_val = PW'(CS_SETUP - 1);
      S_CONV:                    phase_val = PW'(RC_LOW - 1);
      S_PHI, S_PLO, S_NHI, S_NLO: phase_val = PW'(SETTLE);
      default:                   phase_val = '0;
    endcase
  end
  assign phase_load = (state_d != state_q);

  adc_rd_timer #(.W(PW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_val),
    .done     (phase_done)
  );

  assign take_hi = phase_done &
                   ((state_q == S_PHI && !win_exp) || state_q == S_NHI);
  assign take_lo = phase_done &
                   ((state_q == S_PLO && !win_exp) || state_q == S_NLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= 1'b0;
      have_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) mode_q <= prev_read_en_i;
      if (state_q == S_NLO && take_lo) have_q <= 1'b1;
      if (state_q == S_WAIT && !rise_pend_q && !busy_rise && tmo) err_q <= 1'b1;
    end
  end

  adc_rd_assemble u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_hi (take_hi),
    .take_lo (take_lo),
    .bus_i   (bus_i),
    .word_o  (asm_word),
    .stb_o   (asm_stb)
  );

  assign ready_o       = (state_q == S_IDLE);
  assign cs_n_o        = (state_q == S_IDLE);
  assign rc_o          = (state_q != S_CONV);
  assign byte_sel_o    = (state_q == S_PLO) || (state_q == S_NLO);
  assign ext_clk_sel_o = 1'b1;
  assign sclk_o        = 1'b0;
  assign result_o      = asm_word;
  assign valid_o       = asm_stb;
  assign err_o         = err_q;
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
  parameter int SETTLE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic rc_o,
  input logic byte_sel_o,
  input logic valid_o,
  input logic ready_o,
  input logic err_o,
  input logic take_hi,
  input logic take_lo,
  input logic busy_rise
);
  logic [2:0] key_q;
  logic [7:0] age_q, age_now;
  logic       seen_q;
  logic [2:0] key;

  assign key     = {rc_o, cs_n_o, byte_sel_o};
  assign age_now = (key != key_q) ? 8'd0 :
                   ((age_q == 8'hFF) ? age_q : age_q + 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= 3'b110;
      age_q  <= 8'd0;
      seen_q <= 1'b0;
    end else begin
      key_q  <= key;
      age_q  <= age_now;
      seen_q <= seen_q | busy_rise;
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cs_n_o && rc_o));
  a_r2_rc_low_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_o |-> !cs_n_o);
  a_r2_cs_before_rc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_o) |-> $past(!cs_n_o));
  a_r3_sample_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hi || take_lo) |-> (rc_o && !cs_n_o));
  a_r3_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hi || take_lo) |-> (int'(age_now) >= SETTLE));
  a_r4_hi_select: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |-> !byte_sel_o);
  a_r4_lo_select: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo |-> byte_sel_o);
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r9_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> seen_q);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind adc_byte_reader adc_byte_reader_chk #(.SETTLE(SETTLE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_o     (cs_n_o),
  .rc_o       (rc_o),
  .byte_sel_o (byte_sel_o),
  .valid_o    (valid_o),
  .ready_o    (ready_o),
  .err_o      (err_o),
  .take_hi    (take_hi),
  .take_lo    (take_lo),
  .busy_rise  (busy_rise)
);

// File: tb/adc_conv_model.sv
module adc_conv_model #(
  parameter int CONV_CYC = 20
) (
  input  logic        clk,
  input  logic        rc,
  input  logic        cs_n,
  input  logic        byte_sel,
  input  logic [11:0] next_word,
  input  logic        stuck,
  output logic        busy,
  output wire  [7:0]  bus,
  output int          conv_count
);
  logic [11:0] regs_r = 12'h5A5;
  logic        rc_q   = 1'b1;
  logic        busy_r = 1'b1;
  int          cnt    = 0;
  int          convs  = 0;

  always @(posedge clk) begin
    rc_q <= rc;
    if (rc_q && !rc && !cs_n) begin
      busy_r <= 1'b0;
      cnt    <= CONV_CYC;
      convs  <= convs + 1;
    end else if (cnt > 1) begin
      cnt <= cnt - 1;
    end else if (cnt == 1) begin
      cnt <= 0;
      if (!stuck) begin
        regs_r <= next_word;
        busy_r <= 1'b1;
      end
    end
  end

  assign busy       = busy_r;
  assign conv_count = convs;
  assign bus = (rc && !cs_n) ? (byte_sel ? {regs_r[3:0], 4'hC} : regs_r[11:4])
                             : 8'hzz;
endmodule

// File: tb/adc_byte_reader_tb.sv
`timescale 1ns/1ps
module adc_byte_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic stuck = 1'b0;
  logic [11:0] next_word = 12'h000;

  always #4 clk = ~clk;

  logic cs0, rc0, bs0, ext0, sclk0, v0, rdy0, err0, busy0;
  logic cs1, rc1, bs1, ext1, sclk1, v1, rdy1, err1, busy1;
  logic [11:0] r0, r1;
  wire  [7:0] bus0, bus1;
  int conv0, conv1;

  adc_byte_reader #(.CS_SETUP(2), .RC_LOW(3), .SETTLE(2), .WINDOW(40), .TIMEOUT(50)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .prev_read_en_i(mode),
    .busy_i(busy0), .bus_i(bus0), .cs_n_o(cs0), .rc_o(rc0), .byte_sel_o(bs0),
    .ext_clk_sel_o(ext0), .sclk_o(sclk0), .result_o(r0), .valid_o(v0),
    .ready_o(rdy0), .err_o(err0));

  adc_byte_reader #(.CS_SETUP(2), .RC_LOW(3), .SETTLE(2), .WINDOW(4), .TIMEOUT(50)) u_dut_win (
    .clk(clk), .rst_n(rst_n), .start_i(start), .prev_read_en_i(mode),
    .busy_i(busy1), .bus_i(bus1), .cs_n_o(cs1), .rc_o(rc1), .byte_sel_o(bs1),
    .ext_clk_sel_o(ext1), .sclk_o(sclk1), .result_o(r1), .valid_o(v1),
    .ready_o(rdy1), .err_o(err1));

  adc_conv_model #(.CONV_CYC(20)) u_m0 (.clk(clk), .rc(rc0), .cs_n(cs0), .byte_sel(bs0),
    .next_word(next_word), .stuck(stuck), .busy(busy0), .bus(bus0), .conv_count(conv0));
  adc_conv_model #(.CONV_CYC(20)) u_m1 (.clk(clk), .rc(rc1), .cs_n(cs1), .byte_sel(bs1),
    .next_word(next_word), .stuck(stuck), .busy(busy1), .bus(bus1), .conv_count(conv1));

  int checks = 0, errors = 0;
  logic [11:0] res0 [4];
  logic [11:0] res1 [4];
  int n0 = 0, n1 = 0;
  int vcur = 0, vmax = 0;
  int rc_run = 0, rc_width = 0, cs_run = 0, cs_setup = 0;
  logic rc_prev = 1'b1;

  // Observers, sampled away from the active edge.
  always @(negedge clk) begin
    if (v0) begin if (n0 < 4) res0[n0] = r0; n0++; end
    if (v1) begin if (n1 < 4) res1[n1] = r1; n1++; end
    if (v0) vcur++; else vcur = 0;
    if (vcur > vmax) vmax = vcur;
    if (!rc0) rc_run++;
    else if (rc_run > 0) begin rc_width = rc_run; rc_run = 0; end
    if (rc_prev && !rc0) cs_setup = cs_run;
    if (cs0) cs_run = 0; else if (rc0) cs_run++;
    rc_prev = rc0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [11:0] w, input logic m);
    n0 = 0; n1 = 0; vmax = 0;
    next_word = w; mode = m;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (90) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(rdy0 == 1'b1, "R1 ready", int'(rdy0), 1);
    chk(v0 == 1'b0, "R1 valid", int'(v0), 0);
    chk(err0 == 1'b0, "R1 err", int'(err0), 0);
    chk(cs0 == 1'b1 && rc0 == 1'b1, "R1 cs/rc idle", int'({cs0, rc0}), 3);
    chk(ext0 == 1'b1 && sclk0 == 1'b0, "R1 straps", int'({ext0, sclk0}), 2);
  endtask

  task automatic t_first_prev;
    run_conv(12'h3C7, 1'b1);
    chk(n0 == 1, "R9 single strobe first conv", n0, 1);
    chk(res0[0] == 12'h3C7, "R4 first word", int'(res0[0]), 'h3C7);
    chk(n1 == 1, "R9 single strobe first conv win", n1, 1);
    chk(rc_width == 3, "R2 rc low width", rc_width, 3);
    chk(cs_setup == 2, "R2 cs setup", cs_setup, 2);
    chk(vmax == 1, "R5 valid width", vmax, 1);
  endtask

  task automatic t_basic;
    run_conv(12'hFFF, 1'b0);
    chk(n0 == 1 && res0[0] == 12'hFFF, "R4 all ones", int'(res0[0]), 'hFFF);
    run_conv(12'h000, 1'b0);
    chk(n0 == 1 && res0[0] == 12'h000, "R4 all zeros low nibble ignored", int'(res0[0]), 0);
    run_conv(12'h81E, 1'b0);
    chk(n0 == 1 && res0[0] == 12'h81E, "R4 mixed", int'(res0[0]), 'h81E);
    chk(vmax == 1, "R5 valid width", vmax, 1);
  endtask

  task automatic t_prev;
    run_conv(12'h6B2, 1'b1);
    chk(n0 == 2, "R7 two strobes", n0, 2);
    chk(res0[0] == 12'h81E, "R7 earlier result first", int'(res0[0]), 'h81E);
    chk(res0[1] == 12'h6B2, "R7 new result second", int'(res0[1]), 'h6B2);
    chk(n1 == 1, "R8 window abort strobes", n1, 1);
    chk(res1[0] == 12'h6B2, "R8 only new result", int'(res1[0]), 'h6B2);
  endtask

  task automatic t_ignore;
    int c_before;
    c_before = conv0;
    n0 = 0; next_word = 12'h19D; mode = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;
    repeat (70) @(negedge clk);
    chk(conv0 - c_before == 1, "R6 one conversion", conv0 - c_before, 1);
    chk(n0 == 1 && res0[0] == 12'h19D, "R6 one result", n0, 1);
  endtask

  task automatic t_timeout;
    stuck = 1'b1;
    run_conv(12'hABC, 1'b0);
    chk(err0 == 1'b1, "R10 err set", int'(err0), 1);
    chk(rdy0 == 1'b1, "R10 back to ready", int'(rdy0), 1);
    chk(n0 == 0, "R10 no valid", n0, 0);
    stuck = 1'b0;
    run_conv(12'h2E4, 1'b0);
    chk(n0 == 1 && res0[0] == 12'h2E4, "R10 recovers", int'(res0[0]), 'h2E4);
    chk(err0 == 1'b1, "R10 err sticky", int'(err0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_prev();
    t_basic();
    t_prev();
    t_ignore();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule